// File: doc/BRIEF.md
# Masked Receive-Frame Pattern Matcher

This block watches the bytes of received Ethernet frames and raises an interrupt only for frames of interest. A delimiter strobe opens each frame. After it, the block counts byte positions. Starting a programmable number of bytes after the strobe, it compares a window of frame bytes against a stored pattern of up to 64 bytes. Each pattern byte has its own ignore bit, so software can select any subset of header or payload bytes, for example a multicast destination and an EtherType.

Software programs the pattern, the ignore mask, the start offset and the control bits through a byte-wide write port. Every frame raises the delimiter strobe, but only frames whose selected bytes all match produce an event. The event drives the interrupt output in one of two modes. In pulse mode the output is high for one cycle. In level mode the output is held until software writes a clear command.

Top module: `rx_pattern_detect`

## Requirements
- R1: After reset the interrupt output is low, both enables are off and the offset is 0, so no frame raises an event until software configures the block.
- R2: A frame whose window bytes all equal the stored pattern produces an event. Pattern byte i sits at write address i (0 to 63) and is compared with the frame byte at position offset+i, where position 0 is the first valid byte after the delimiter strobe.
- R3: Mask bytes live at addresses 64 to 71. Address 64+k bit b is the ignore bit for pattern byte 8k+b. A pattern byte whose ignore bit is 1 always counts as matching.
- R4: The byte offset register at address 72 (8 bits) sets the frame position where the window begins. The same content placed one position earlier does not match.
- R5: The control register is at address 73. Bit 0 is the detect enable, bit 1 is the pattern enable and bit 2 selects level mode. An event is raised only while both enables are 1.
- R6: In pulse mode (control bit 2 = 0) each matching frame drives the interrupt high for exactly one cycle. Writing the clear command has no effect in this mode.
- R7: In level mode the interrupt rises on a matching frame and stays high through later frames, whether they match or not. It stays high until a write to address 74 with data bit 0 set, which drops it on the next cycle.
- R8: If the end-of-frame strobe arrives before the last window byte, the frame reports no event.
- R9: A mismatch on any byte that is not ignored blocks the event for that frame, whatever the position of that byte in the window.
- R10: Configuration writes made during a frame do not affect that frame. They take effect from the next delimiter strobe.
- R11: A delimiter strobe restarts position counting and clears the mismatch state, even if the previous frame never ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_sof | input | 1 | Delimiter strobe; opens a frame (no byte is taken in that cycle) |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_eof | input | 1 | End-of-frame strobe (no byte is taken in that cycle) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| irq | output | 1 | Match event interrupt |

## Verification
The embedded assertions check the following on every cycle:
- An event only follows a byte compared while both enables were set.
- A pulse never lasts two cycles.
- A held level survives until a clear.
- A clear in level mode drops the output.
- The per-frame mismatch state cannot reset in the middle of a frame.

Whether the right frames match needs the bench's scenarios. These cover:
- a sweep of a single corrupted byte over every window position, under several masks and offsets;
- shifted content;
- truncated frames;
- restarted frames;
- writes made in the middle of a frame.

// File: rtl/rxpm_pkg.sv
package rxpm_pkg;

    localparam int MAX_WIN   = 64;
    localparam int ADDR_W    = 7;
    localparam int PAT_BASE  = 0;
    localparam int MASK_BASE = 64;
    localparam int OFS_ADDR  = 72;
    localparam int CTRL_ADDR = 73;
    localparam int CLR_ADDR  = 74;

    typedef struct packed {
        logic       lvl_mode;
        logic       pat_en;
        logic       det_en;
        logic [7:0] offset;
    } match_ctrl_t;

endpackage

// File: rtl/rxpm_cfg.sv
module rxpm_cfg
    import rxpm_pkg::*;
#(
    parameter int WIN = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  frame_start,
    output logic [WIN-1:0][7:0]   pat_act,
    output logic [WIN-1:0]        mask_act,
    output match_ctrl_t           ctrl_act,
    output logic                  clr_cmd
);

    typedef struct packed {
        logic [WIN-1:0][7:0] pat_sh;
        logic [WIN-1:0]      mask_sh;
        match_ctrl_t         ctrl_sh;
        logic [WIN-1:0][7:0] pat_a;
        logic [WIN-1:0]      mask_a;
        match_ctrl_t         ctrl_a;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < WIN; i++) begin
                if (int'(wr_addr) == PAT_BASE + i) st_d.pat_sh[i] = wr_data;
                if (int'(wr_addr) == MASK_BASE + i / 8) st_d.mask_sh[i] = wr_data[i % 8];
            end
            if (int'(wr_addr) == OFS_ADDR) st_d.ctrl_sh.offset = wr_data;
            if (int'(wr_addr) == CTRL_ADDR) begin
                st_d.ctrl_sh.det_en   = wr_data[0];
                st_d.ctrl_sh.pat_en   = wr_data[1];
                st_d.ctrl_sh.lvl_mode = wr_data[2];
            end
        end
        if (frame_start) begin
            st_d.pat_a  = st_q.pat_sh;
            st_d.mask_a = st_q.mask_sh;
            st_d.ctrl_a = st_q.ctrl_sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pat_act  = st_q.pat_a;
    assign mask_act = st_q.mask_a;
    assign ctrl_act = st_q.ctrl_a;
    assign clr_cmd  = wr_en && (int'(wr_addr) == CLR_ADDR) && wr_data[0];

    // R10: the working copy only moves on a delimiter strobe
    assert_active_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(st_q.ctrl_a));

endmodule

// File: rtl/rxpm_window.sv
module rxpm_window
    import rxpm_pkg::*;
#(
    parameter int WIN = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sof,
    input  logic                 eof,
    input  logic                 valid,
    input  logic [7:0]           data,
    input  logic [WIN-1:0][7:0]  pat,
    input  logic [WIN-1:0]       mask,
    input  logic [7:0]           offset,
    input  logic                 armed,
    output logic                 hit
);

    localparam int POS_W = $clog2(256 + WIN + 1);
    localparam int IDX_W = (WIN > 1) ? $clog2(WIN) : 1;

    typedef struct packed {
        logic             in_frame;
        logic             done;
        logic             fail;
        logic [POS_W-1:0] pos;
        logic             hit;
    } win_state_t;

    win_state_t st_d, st_q;

    logic [POS_W-1:0] rel;
    logic [IDX_W-1:0] idx;
    logic             in_win;
    logic             mism;
    logic             last;

    always_comb begin
        rel    = st_q.pos - POS_W'(offset);
        idx    = rel[IDX_W-1:0];
        in_win = st_q.pos >= POS_W'(offset);
        mism   = !mask[idx] && (data != pat[idx]);
        last   = rel == POS_W'(WIN - 1);

        st_d     = st_q;
        st_d.hit = 1'b0;
        if (sof) begin
            st_d.in_frame = 1'b1;
            st_d.done     = 1'b0;
            st_d.fail     = 1'b0;
            st_d.pos      = '0;
        end else if (eof) begin
            st_d.in_frame = 1'b0;
        end else if (valid && st_q.in_frame && !st_q.done) begin
            st_d.pos = st_q.pos + 1'b1;
            if (in_win) begin
                if (last) begin
                    st_d.done = 1'b1;
                    st_d.hit  = armed && !(st_q.fail || mism);
                end else begin
                    st_d.fail = st_q.fail || mism;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit = st_q.hit;

    // R9: a recorded mismatch persists until the next delimiter
    assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fail && !sof |=> st_q.fail);
    // R6: one evaluation per frame, so never two event cycles in a row
    assert_single_eval_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hit |=> !st_q.hit);
    // R2: an event only follows a valid byte inside an open frame
    assert_hit_from_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hit |-> $past(valid && st_q.in_frame));

endmodule

// File: rtl/rxpm_irq.sv
module rxpm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic lvl_mode,
    input  logic clr,
    output logic irq
);

    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lvl_mode) st_d.irq = hit || (st_q.irq && !clr);
        else          st_d.irq = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |-> !st_q.irq);
    assert_pulse_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_mode && st_q.irq && !hit |=> !st_q.irq);
    assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_mode && st_q.irq && !clr ##1 lvl_mode |-> st_q.irq);
    assert_level_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_mode && clr && !hit ##1 lvl_mode |-> !st_q.irq);

endmodule

// File: rtl/rx_pattern_detect.sv
module rx_pattern_detect
    import rxpm_pkg::*;
#(
    parameter int WIN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_eof,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic              irq
);

    logic [WIN-1:0][7:0] pat_act;
    logic [WIN-1:0]      mask_act;
    match_ctrl_t         ctrl_act;
    logic                clr_cmd;
    logic                hit;
    logic                armed;

    rxpm_cfg #(.WIN(WIN)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_addr     (cfg_addr),
        .wr_data     (cfg_wdata),
        .frame_start (rx_sof),
        .pat_act     (pat_act),
        .mask_act    (mask_act),
        .ctrl_act    (ctrl_act),
        .clr_cmd     (clr_cmd)
    );

    assign armed = ctrl_act.det_en && ctrl_act.pat_en;

    rxpm_window #(.WIN(WIN)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .sof    (rx_sof),
        .eof    (rx_eof),
        .valid  (rx_valid),
        .data   (rx_data),
        .pat    (pat_act),
        .mask   (mask_act),
        .offset (ctrl_act.offset),
        .armed  (armed),
        .hit    (hit)
    );

    rxpm_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .lvl_mode (ctrl_act.lvl_mode),
        .clr      (clr_cmd),
        .irq      (irq)
    );

    // R5: an event requires both enables during the deciding byte
    assert_hit_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(ctrl_act.det_en && ctrl_act.pat_en));

endmodule

// File: tb/rx_pattern_detect_test.sv
module rx_pattern_detect_test;

    localparam int WIN = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0;
    logic [7:0] rx_data = '0;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       irq;

    int checks = 0, failures = 0, irq_cnt = 0;
    bit finished = 0;
    logic [7:0]     pat_m [WIN];
    logic [WIN-1:0] mask_m;

    always #2.5 clk = ~clk;

    rx_pattern_detect #(.WIN(WIN)) uut (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_eof(rx_eof), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq(irq)
    );

    always @(negedge clk) if (irq === 1'b1) irq_cnt++;

    task automatic chk(input int got, input int exp, input string req);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_mask(input logic [WIN-1:0] m);
        mask_m = m;
        for (int k = 0; k < WIN / 8; k++) wr(64 + k, int'(m[k*8 +: 8]));
    endtask

    // frame with window content starting at position off+shift; flip corrupts one window byte
    task automatic send_frame(input int off, input int len, input int flip,
                              input int shift, input int wr_at, input int wa, input int wd);
        irq_cnt = 0;
        @(negedge clk); rx_sof = 1'b1;
        @(negedge clk); rx_sof = 1'b0;
        for (int p = 0; p < len; p++) begin
            int rel;
            rel = p - (off + shift);
            rx_valid = 1'b1;
            if (rel >= 0 && rel < WIN)
                rx_data = pat_m[rel] ^ ((rel == flip) ? 8'h5A : 8'h00);
            else
                rx_data = 8'(p * 13 + 200);
            cfg_we = (p == wr_at);
            cfg_addr = 7'(wa); cfg_wdata = 8'(wd);
            @(negedge clk);
        end
        rx_valid = 1'b0; cfg_we = 1'b0;
        rx_eof = 1'b1;
        @(negedge clk); rx_eof = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [WIN-1:0] masks [3];
        int offs [3];
        masks[0] = '0;
        masks[1] = 64'hF0F0_0000_FFFF_0001;
        masks[2] = 64'h0123_4567_89AB_CDEE;
        offs[0] = 0; offs[1] = 3; offs[2] = 17;
        for (int i = 0; i < WIN; i++) pat_m[i] = 8'(i * 37 + 11);
        mask_m = '0;

        repeat (3) @(negedge clk);
        chk(int'(irq), 0, "R1 irq low in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(irq), 0, "R1 irq low after reset");
        // R1: all-zero frame against the reset pattern, enables still off
        for (int i = 0; i < WIN; i++) pat_m[i] = 8'h00;
        send_frame(0, WIN + 3, -1, 0, -1, 0, 0);
        chk(irq_cnt, 0, "R1 no event while unconfigured");
        for (int i = 0; i < WIN; i++) pat_m[i] = 8'(i * 37 + 11);

        for (int i = 0; i < WIN; i++) wr(i, int'(pat_m[i]));
        wr(73, 3);

        // R2 R3 R4 R9 sweep: one corrupted byte at every window position
        for (int o = 0; o < 3; o++) begin
            wr(72, offs[o]);
            for (int m = 0; m < 3; m++) begin
                load_mask(masks[m]);
                send_frame(offs[o], offs[o] + WIN + 3, -1, 0, -1, 0, 0);
                chk(irq_cnt, 1, "R2 clean frame matches");
                for (int j = 0; j < WIN; j++) begin
                    send_frame(offs[o], offs[o] + WIN + 3, j, 0, -1, 0, 0);
                    if (mask_m[j]) chk(irq_cnt, 1, "R3 ignored byte corrupted");
                    else           chk(irq_cnt, 0, "R9 unmasked byte corrupted");
                end
            end
        end

        // R4: content one byte early under offset 17 does not match
        load_mask(masks[1]);
        send_frame(17, 17 + WIN + 3, -1, -1, -1, 0, 0);
        chk(irq_cnt, 0, "R4 shifted content");
        send_frame(17, 17 + WIN + 3, -1, 0, -1, 0, 0);
        chk(irq_cnt, 1, "R4 aligned content");

        // R8: frame ends one byte short of the window
        send_frame(17, 17 + WIN - 1, -1, 0, -1, 0, 0);
        chk(irq_cnt, 0, "R8 truncated frame");

        // R5: each enable alone is not enough
        wr(73, 1);
        send_frame(17, 17 + WIN + 3, -1, 0, -1, 0, 0);
        chk(irq_cnt, 0, "R5 detect enable only");
        wr(73, 2);
        send_frame(17, 17 + WIN + 3, -1, 0, -1, 0, 0);
        chk(irq_cnt, 0, "R5 pattern enable only");
        wr(73, 3);
        send_frame(17, 17 + WIN + 3, -1, 0, -1, 0, 0);
        chk(irq_cnt, 1, "R5 both enables");

        // R11: restart mid-frame, no end strobe in between
        @(negedge clk); rx_sof = 1'b1;
        @(negedge clk); rx_sof = 1'b0;
        for (int p = 0; p < 30; p++) begin
            rx_valid = 1'b1; rx_data = 8'(p ^ 8'hC3);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        send_frame(17, 17 + WIN + 3, -1, 0, -1, 0, 0);
        chk(irq_cnt, 1, "R11 restart then clean frame");

        // R10: pattern byte 2 rewritten mid-frame; old pattern still governs this frame
        load_mask('0);
        wr(72, 0);
        send_frame(0, WIN + 3, -1, 0, 10, 2, int'(pat_m[2] ^ 8'h5A));
        chk(irq_cnt, 1, "R10 mid-frame write deferred");
        send_frame(0, WIN + 3, 2, 0, -1, 0, 0);
        chk(irq_cnt, 1, "R10 new pattern after delimiter");
        send_frame(0, WIN + 3, -1, 0, -1, 0, 0);
        chk(irq_cnt, 0, "R10 old content no longer matches");
        wr(2, int'(pat_m[2]));

        // R6: clear in pulse mode changes nothing
        wr(74, 1);
        chk(int'(irq), 0, "R6 clear in pulse mode");
        send_frame(0, WIN + 3, -1, 0, -1, 0, 0);
        chk(irq_cnt, 1, "R6 single pulse after clear");

        // R7: level mode
        wr(73, 7);
        send_frame(0, WIN + 3, -1, 0, -1, 0, 0);
        chk(int'(irq), 1, "R7 level raised");
        repeat (10) @(negedge clk);
        chk(int'(irq), 1, "R7 level held idle");
        send_frame(0, WIN + 3, 5, 0, -1, 0, 0);
        chk(int'(irq), 1, "R7 level held over mismatch frame");
        wr(74, 0);
        chk(int'(irq), 1, "R7 write without clear bit");
        wr(74, 1);
        chk(int'(irq), 0, "R7 level cleared");
        send_frame(0, WIN + 3, 5, 0, -1, 0, 0);
        chk(int'(irq), 0, "R7 stays low after clear");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule